// File: doc/BRIEF.md
# PCM bus clock and frame-sync master

This block produces the timing of a PCM serial audio bus when the device owns that bus. From a fast reference clock it divides down a serial bit clock and a frame-sync pulse that marks the start of every frame. A frame holds a programmable number of data bit periods and may be followed by a programmable idle stretch. During the idle stretch the bit clock stops and stays low. For the serial transceiver beside it, the block also provides a one-cycle bit strobe, a one-cycle frame-start strobe and the index of the current bit period.

Software writes a new setting as a divide value, a frame length and an idle length together, with one write strobe. A write whose divide value would push the bit clock above 4.096 MHz or below 64 kHz is dropped whole. A write whose frame length is zero or longer than the frame limit is also dropped whole. An accepted write waits in a staging register and is applied only where one frame ends and the next begins, so a frame in progress keeps its timing. Dropping the enable input stops the bus at once. Raising it again starts a fresh frame on the next cycle.

Top module: `pcm_bus_timing_master`

## Requirements
- R1: While reset is high, and in every cycle after a cycle in which `enable` was low, `bclk_o`, `fsync_o`, `bit_en_o` and `frame_start_o` are 0 and `bit_idx_o` is 0.
- R2: With an active divide value H, every data bit period lasts 2·H reference cycles. `bclk_o` is high for the first H cycles and low for the last H.
- R3: `fsync_o` is high for exactly the first bit period (2·H cycles) of each frame. `frame_start_o` is high only in the first reference cycle of each frame.
- R4: With frame length F and idle length I, successive frame starts are exactly (F+I)·2·H reference cycles apart.
- R5: During the I idle bit periods that follow the F data bit periods, `bclk_o` stays 0 and `bit_en_o` stays 0.
- R6: An idle length of 0 makes frames follow each other back to back with no stopped-clock time.
- R7: A write with `cfg_half` below ceil(REF_HZ/8.192 MHz) or above floor(REF_HZ/128 kHz) is rejected whole, and the previous setting stays in force.
- R8: A write with `cfg_frame` equal to 0 or greater than MAX_FRAME is rejected whole, and the previous setting stays in force. The limit values themselves are accepted.
- R9: An accepted write does not change the frame in progress. It takes effect from the next frame start.
- R10: `bit_en_o` is high for one reference cycle at each rising edge of `bclk_o`, which is the first cycle of each data bit period. `bit_idx_o` counts the bit periods of the frame from 0, idle periods included.
- R11: When `enable` rises again after being low, the cycle that follows shows a new frame start: `frame_start_o`, `fsync_o`, `bclk_o` and `bit_en_o` are 1 and `bit_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the bus when high. When low, clears the outputs and the counters |
| cfg_wr | input | 1 | One-cycle strobe that offers a new setting |
| cfg_half | input | DIV_W | Bit-clock half period, in reference cycles |
| cfg_frame | input | FLEN_W | Data bit periods per frame (1..MAX_FRAME) |
| cfg_idle | input | IDLE_W | Idle bit periods after the data. 0 means none |
| bclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame sync, high during bit period 0 |
| bit_en_o | output | 1 | One-cycle strobe at each data bit-clock rise |
| frame_start_o | output | 1 | One-cycle strobe at each frame start |
| bit_idx_o | output | SLOT_W | Index of the current bit period in the frame |

## Verification
The bench builds the block with a 16.384 MHz reference, a 4-bit idle field and a reset setting of H=4, F=8, I=2. These values make the legal divide range 2..128. The fastest divide (2), the slowest (128), the longest frame (80 bits) and the largest idle (15 periods) each then fit in a frame of at most about a thousand cycles. Every frame is compared cycle by cycle against a waveform the bench computes from H, F and I. Settings are written part-way through a frame, so the bench can see both that the frame in progress keeps its timing and that each rejected value leaves the old timing in place.

// File: rtl/pcmm_pkg.sv
package pcmm_pkg;

  // Half of a bit period: the clock is high in the first half, low in the second.
  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } bit_phase_e;

endpackage

// File: rtl/pcmm_cfg_stage.sv
module pcmm_cfg_stage #(
  parameter int DIV_W     = 8,
  parameter int FLEN_W    = 7,
  parameter int IDLE_W    = 8,
  parameter int MIN_HALF  = 3,
  parameter int MAX_HALF  = 192,
  parameter int MAX_FRAME = 80,
  parameter int DEF_HALF  = 6,
  parameter int DEF_FRAME = 64,
  parameter int DEF_IDLE  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DIV_W-1:0]  wr_half,
  input  logic [FLEN_W-1:0] wr_frame,
  input  logic [IDLE_W-1:0] wr_idle,
  input  logic              load,
  output logic [DIV_W-1:0]  act_half,
  output logic [FLEN_W-1:0] act_frame,
  output logic [IDLE_W-1:0] act_idle
);

  localparam logic [DIV_W-1:0]  LO_H  = DIV_W'(MIN_HALF);
  localparam logic [DIV_W-1:0]  HI_H  = DIV_W'(MAX_HALF);
  localparam logic [FLEN_W-1:0] HI_F  = FLEN_W'(MAX_FRAME);
  localparam logic [DIV_W-1:0]  RST_H = DIV_W'(DEF_HALF);
  localparam logic [FLEN_W-1:0] RST_F = FLEN_W'(DEF_FRAME);
  localparam logic [IDLE_W-1:0] RST_I = IDLE_W'(DEF_IDLE);

  logic [DIV_W-1:0]  pend_half;
  logic [FLEN_W-1:0] pend_frame;
  logic [IDLE_W-1:0] pend_idle;
  logic              wr_legal;

  // Whole-write rejection: any illegal field discards all three.
  always_comb begin
    wr_legal = (wr_half >= LO_H) && (wr_half <= HI_H) &&
               (wr_frame != '0) && (wr_frame <= HI_F);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_half  <= RST_H;
      pend_frame <= RST_F;
      pend_idle  <= RST_I;
    end else if (wr && wr_legal) begin
      pend_half  <= wr_half;
      pend_frame <= wr_frame;
      pend_idle  <= wr_idle;
    end
  end

  // Active copy only moves at a frame boundary (or bus start).
  always_ff @(posedge clk) begin
    if (rst) begin
      act_half  <= RST_H;
      act_frame <= RST_F;
      act_idle  <= RST_I;
    end else if (load) begin
      act_half  <= pend_half;
      act_frame <= pend_frame;
      act_idle  <= pend_idle;
    end
  end

  p_half_legal_r7: assert property (@(posedge clk) disable iff (rst)
    (act_half >= LO_H) && (act_half <= HI_H));

  p_frame_legal_r8: assert property (@(posedge clk) disable iff (rst)
    (act_frame != '0) && (act_frame <= HI_F));

  p_hold_midframe_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({act_half, act_frame, act_idle}));

endmodule

// File: rtl/pcmm_half_timer.sv
module pcmm_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_lim,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_comb begin
    tick = run && (cnt == (half_lim - DIV_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < half_lim));

endmodule

// File: rtl/pcmm_frame_seq.sv
module pcmm_frame_seq
  import pcmm_pkg::*;
#(
  parameter int FLEN_W = 7,
  parameter int IDLE_W = 8,
  parameter int SLOT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              tick,
  input  logic [FLEN_W-1:0] act_frame,
  input  logic [IDLE_W-1:0] act_idle,
  output logic              running,
  output logic              load_cfg,
  output logic              bclk,
  output logic              fsync,
  output logic              bit_en,
  output logic              frame_start,
  output logic [SLOT_W-1:0] slot
);

  localparam int SUM_W = SLOT_W + 1;

  bit_phase_e       phase;
  logic [SUM_W-1:0] nxt_slot;
  logic [SUM_W-1:0] total;
  logic             last_slot;
  logic             data_next;
  logic             starting;
  logic             wrap;

  always_comb begin
    nxt_slot  = SUM_W'(slot) + SUM_W'(1);
    total     = SUM_W'(act_frame) + SUM_W'(act_idle);
    last_slot = (nxt_slot == total);
    data_next = (nxt_slot < SUM_W'(act_frame));
    starting  = enable && !running;
    wrap      = enable && running && tick && (phase == PH_LOW) && last_slot;
    load_cfg  = starting || wrap;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      running     <= 1'b0;
      phase       <= PH_HIGH;
      slot        <= '0;
      bclk        <= 1'b0;
      fsync       <= 1'b0;
      bit_en      <= 1'b0;
      frame_start <= 1'b0;
    end else if (!running) begin
      running     <= 1'b1;
      phase       <= PH_HIGH;
      slot        <= '0;
      bclk        <= 1'b1;
      fsync       <= 1'b1;
      bit_en      <= 1'b1;
      frame_start <= 1'b1;
    end else begin
      bit_en      <= 1'b0;
      frame_start <= 1'b0;
      if (tick) begin
        if (phase == PH_HIGH) begin
          phase <= PH_LOW;
          bclk  <= 1'b0;
        end else begin
          phase <= PH_HIGH;
          if (last_slot) begin
            slot        <= '0;
            bclk        <= 1'b1;
            fsync       <= 1'b1;
            bit_en      <= 1'b1;
            frame_start <= 1'b1;
          end else begin
            slot   <= slot + SLOT_W'(1);
            fsync  <= 1'b0;
            bclk   <= data_next;
            bit_en <= data_next;
          end
        end
      end
    end
  end

  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> (!bclk && !fsync && !bit_en && !frame_start && (slot == '0)));

  p_sync_first_bit_r3: assert property (@(posedge clk) disable iff (rst)
    fsync |-> (slot == '0));

  p_start_marks_frame_r3: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (fsync && bclk && bit_en));

  p_idle_clock_low_r5: assert property (@(posedge clk) disable iff (rst)
    (running && (SUM_W'(slot) >= SUM_W'(act_frame))) |-> (!bclk && !bit_en));

  p_strobe_on_rise_r10: assert property (@(posedge clk) disable iff (rst)
    bit_en |-> (bclk && !$past(bclk)));

  p_restart_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && !$past(running)) |-> (frame_start && (slot == '0)));

endmodule

// File: rtl/pcm_bus_timing_master.sv
module pcm_bus_timing_master #(
  parameter int REF_HZ      = 24_576_000,
  parameter int MAX_BCLK_HZ = 4_096_000,
  parameter int MIN_BCLK_HZ = 64_000,
  parameter int MAX_FRAME   = 80,
  parameter int IDLE_W      = 8,
  parameter int DEF_HALF    = 6,
  parameter int DEF_FRAME   = 64,
  parameter int DEF_IDLE    = 0,
  localparam int MIN_HALF   = (REF_HZ + 2 * MAX_BCLK_HZ - 1) / (2 * MAX_BCLK_HZ),
  localparam int MAX_HALF   = REF_HZ / (2 * MIN_BCLK_HZ),
  localparam int DIV_W      = $clog2(MAX_HALF + 1),
  localparam int FLEN_W     = $clog2(MAX_FRAME + 1),
  localparam int SLOT_W     = $clog2(MAX_FRAME + (1 << IDLE_W))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cfg_wr,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [FLEN_W-1:0] cfg_frame,
  input  logic [IDLE_W-1:0] cfg_idle,
  output logic              bclk_o,
  output logic              fsync_o,
  output logic              bit_en_o,
  output logic              frame_start_o,
  output logic [SLOT_W-1:0] bit_idx_o
);

  logic [DIV_W-1:0]  act_half;
  logic [FLEN_W-1:0] act_frame;
  logic [IDLE_W-1:0] act_idle;
  logic              running;
  logic              load_cfg;
  logic              tick;

  pcmm_cfg_stage #(
    .DIV_W    (DIV_W),
    .FLEN_W   (FLEN_W),
    .IDLE_W   (IDLE_W),
    .MIN_HALF (MIN_HALF),
    .MAX_HALF (MAX_HALF),
    .MAX_FRAME(MAX_FRAME),
    .DEF_HALF (DEF_HALF),
    .DEF_FRAME(DEF_FRAME),
    .DEF_IDLE (DEF_IDLE)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr       (cfg_wr),
    .wr_half  (cfg_half),
    .wr_frame (cfg_frame),
    .wr_idle  (cfg_idle),
    .load     (load_cfg),
    .act_half (act_half),
    .act_frame(act_frame),
    .act_idle (act_idle)
  );

  pcmm_half_timer #(
    .DIV_W(DIV_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (running),
    .half_lim(act_half),
    .tick    (tick)
  );

  pcmm_frame_seq #(
    .FLEN_W(FLEN_W),
    .IDLE_W(IDLE_W),
    .SLOT_W(SLOT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .tick       (tick),
    .act_frame  (act_frame),
    .act_idle   (act_idle),
    .running    (running),
    .load_cfg   (load_cfg),
    .bclk       (bclk_o),
    .fsync      (fsync_o),
    .bit_en     (bit_en_o),
    .frame_start(frame_start_o),
    .slot       (bit_idx_o)
  );

endmodule

// File: tb/pcm_bus_timing_master_tb.sv
module pcm_bus_timing_master_tb;

  localparam int REF_HZ = 16_384_000;
  localparam int IDLE_W = 4;
  localparam int DIV_W  = 8;
  localparam int FLEN_W = 7;
  localparam int SLOT_W = 7;

  logic              clk = 1'b0;
  logic              rst;
  logic              enable;
  logic              cfg_wr;
  logic [DIV_W-1:0]  cfg_half;
  logic [FLEN_W-1:0] cfg_frame;
  logic [IDLE_W-1:0] cfg_idle;
  logic              bclk_o;
  logic              fsync_o;
  logic              bit_en_o;
  logic              frame_start_o;
  logic [SLOT_W-1:0] bit_idx_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pcm_bus_timing_master #(
    .REF_HZ   (REF_HZ),
    .IDLE_W   (IDLE_W),
    .DEF_HALF (4),
    .DEF_FRAME(8),
    .DEF_IDLE (2)
  ) u_dut (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .cfg_wr       (cfg_wr),
    .cfg_half     (cfg_half),
    .cfg_frame    (cfg_frame),
    .cfg_idle     (cfg_idle),
    .bclk_o       (bclk_o),
    .fsync_o      (fsync_o),
    .bit_en_o     (bit_en_o),
    .frame_start_o(frame_start_o),
    .bit_idx_o    (bit_idx_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called with the current negedge sample on cycle 0 of a frame.
  // Outputs packed as {bclk, fsync, bit_en, frame_start}.
  task automatic expect_frame(input int h, input int f, input int i,
                              input int wk, input int wh, input int wf,
                              input int wi, input string req);
    int per = (f + i) * 2 * h;
    int bad_k = -1;
    int bad_act = 0;
    int bad_exp = 0;
    int idx_k = -1;
    int idx_act = 0;
    int idx_exp = 0;
    for (int k = 0; k < per; k++) begin
      int b  = k / (2 * h);
      int ph = k % (2 * h);
      int e  = {((b < f) && (ph < h)), (b == 0), ((b < f) && (ph == 0)), (k == 0)};
      int a  = {bclk_o, fsync_o, bit_en_o, frame_start_o};
      if ((a != e) && (bad_k < 0)) begin
        bad_k = k; bad_act = a; bad_exp = e;
      end
      if ((int'(bit_idx_o) != b) && (idx_k < 0)) begin
        idx_k = k; idx_act = int'(bit_idx_o); idx_exp = b;
      end
      if (k == wk) begin
        cfg_wr    = 1'b1;
        cfg_half  = DIV_W'(wh);
        cfg_frame = FLEN_W'(wf);
        cfg_idle  = IDLE_W'(wi);
      end else begin
        cfg_wr = 1'b0;
      end
      @(negedge clk);
    end
    cfg_wr = 1'b0;
    check(bad_k < 0, req, $sformatf("waveform {bclk,fsync,bit_en,start} at cycle %0d", bad_k),
          bad_act, bad_exp);
    check(idx_k < 0, "R10", $sformatf("bit index at cycle %0d", idx_k), idx_act, idx_exp);
    check(frame_start_o && (bit_idx_o == '0), "R4", "next frame start after period",
          int'(frame_start_o), 1);
  endtask

  task automatic t_reset();
    rst = 1'b1; enable = 1'b0; cfg_wr = 1'b0;
    cfg_half = '0; cfg_frame = '0; cfg_idle = '0;
    repeat (4) @(negedge clk);
    check({bclk_o, fsync_o, bit_en_o, frame_start_o} == 4'b0, "R1", "outputs in reset",
          int'({bclk_o, fsync_o, bit_en_o, frame_start_o}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check({bclk_o, fsync_o, bit_en_o, frame_start_o} == 4'b0 && bit_idx_o == '0, "R1",
          "outputs while disabled", int'({bclk_o, fsync_o, bit_en_o, frame_start_o}), 0);
  endtask

  task automatic t_start_default();
    enable = 1'b1;
    @(negedge clk);
    check(frame_start_o && bclk_o && fsync_o, "R11", "first frame start after enable",
          int'(frame_start_o), 1);
    expect_frame(4, 8, 2, -1, 0, 0, 0, "R2 R3 R5");
  endtask

  task automatic t_deferred_and_no_idle();
    // R9: write lands mid-frame; this frame keeps H=4 F=8 I=2.
    expect_frame(4, 8, 2, 10, 2, 5, 0, "R9");
    // R6: back-to-back frames with the new setting.
    expect_frame(2, 5, 0, -1, 0, 0, 0, "R6");
  endtask

  task automatic t_reject();
    expect_frame(2, 5, 0, 3, 1, 6, 1, "R7");     // too fast
    expect_frame(2, 5, 0, 3, 200, 6, 1, "R7");   // too slow
    expect_frame(2, 5, 0, 3, 3, 0, 1, "R8");     // zero length
    expect_frame(2, 5, 0, 3, 3, 81, 1, "R8");    // too long
    expect_frame(2, 5, 0, -1, 0, 0, 0, "R7 R8");
  endtask

  task automatic t_limits();
    expect_frame(2, 5, 0, 3, 2, 80, 0, "R8");
    expect_frame(2, 80, 0, 3, 128, 1, 3, "R7 R8");
    expect_frame(128, 1, 3, 3, 3, 3, 15, "R5 R7");
    expect_frame(3, 3, 15, -1, 0, 0, 0, "R5");
  endtask

  task automatic t_disable_restart();
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check({bclk_o, fsync_o, bit_en_o, frame_start_o} == 4'b0 && bit_idx_o == '0, "R1",
          "cleared after disable", int'({bclk_o, fsync_o, bit_en_o, frame_start_o}), 0);
    repeat (4) @(negedge clk);
    check({bclk_o, fsync_o} == 2'b0, "R1", "stays low while disabled",
          int'({bclk_o, fsync_o}), 0);
    enable = 1'b1;
    @(negedge clk);
    check(frame_start_o && fsync_o && bclk_o && bit_en_o && bit_idx_o == '0, "R11",
          "restart strobes", int'({bclk_o, fsync_o, bit_en_o, frame_start_o}), 15);
    expect_frame(3, 3, 15, -1, 0, 0, 0, "R11");
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_start_default();
    t_deferred_and_no_idle();
    t_reject();
    t_limits();
    t_disable_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule